// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block drives the SDRAM power-up series after software sets a start bit in its control register. It issues a Precharge of all banks, a Refresh and a Mode Register Set, in one of two orders chosen by a control bit. Each command lasts one clock. A fixed number of idle (NOP) cycles follows each command, set per command type by the parameters `T_RP`, `T_MRD` and `T_RFC`. A busy flag covers the whole series, and the start bit reads back as that flag, so it clears by itself when the series ends.

The same register holds a clock-keep bit. This bit decides whether the SDRAM clock is gated off while the memory self-refreshes, and whether the clock pin stays driven while the bus is released. There are two resets. A cold reset restores the configuration defaults. A hot reset stops any running series but keeps both configuration bits.

Top module: `sdram_init_seq`

## Requirements
- R1: Writing 1 to bit 6 of the control register while idle starts a series. `busy` is high from the next clock onwards. Bit 6 reads 1 while `busy` is high and reads 0 once the series is over.
- R2: When order bit 4 is 0, the commands are Precharge, then Refresh, then Mode Register Set.
- R3: When order bit 4 is 1, the commands are Precharge, then Mode Register Set, then Refresh.
- R4: Command pins {cs_n,ras_n,cas_n,we_n} use these encodings: NOP 0111, Precharge 0010, Refresh 0001, Mode Register Set 0000. Precharge drives address bit 10 high. Mode Register Set drives `cfg_mode` onto the address outputs.
- R5: The first command appears two clocks after the start write is sampled, and each command lasts one clock. After Precharge come T_RP NOP cycles, after Mode Register Set T_MRD, and after Refresh T_RFC (defaults 3, 2 and 7). `busy` reads low from the T-th cycle after the last command, where T is the wait of that command.
- R6: While `busy` is high, a write to the control register has no effect: no new series starts and the order and keep bits are unchanged.
- R7: With keep bit 3 at 0 and `self_refresh` high, `sdr_clk_en` is low one clock later.
- R8: With keep bit 3 at 0 and `bus_released` high, `sdr_clk_oe` is low one clock later.
- R9: With keep bit 3 at 1, `sdr_clk_en` and `sdr_clk_oe` are high one clock later, whatever `self_refresh` and `bus_released` are.
- R10: A cold reset (`rst`) clears the order bit to 0 and sets the keep bit to 1, so the register reads 0x08. It leaves the block idle, with NOP on the command pins and both clock controls high.
- R11: A hot reset (`hot_rst`) abandons a running series without issuing further commands and clears `busy`. It keeps the order and keep bits.
- R12: Reads return bit 6 = busy, bit 4 = order and bit 3 = keep. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Cold reset, synchronous, active high |
| hot_rst | input | 1 | Hot reset, synchronous, active high; keeps configuration |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| cfg_mode | input | ADDR_W | Value placed on the address outputs during Mode Register Set |
| self_refresh | input | 1 | SDRAM is in self-refresh |
| bus_released | input | 1 | External bus is released to another master |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_addr | output | ADDR_W | SDRAM address outputs |
| busy | output | 1 | Series in progress |
| sdr_clk_en | output | 1 | SDRAM clock runs when high |
| sdr_clk_oe | output | 1 | Clock pin driven when high, high impedance when low |

## Verification
The series is started once with each setting of the order bit. The scoreboard then expects the two different command lists and the gap each command type sets, which separates a swapped order from wrong wait counts. A third start is followed by a conflicting write while busy, which shows whether a running series can be re-triggered or its order changed. The clock controls are driven with self-refresh and bus-release, each under both keep settings, so a swapped or missing condition shows up. A hot reset and a cold reset, each after non-default configuration, show which state each reset keeps.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } seq_state_e;
endpackage

// File: rtl/sdram_init_regs.sv
module sdram_init_regs (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       busy,
  output logic       order_q,
  output logic       keep_q,
  output logic       start,
  output logic [7:0] rdata
);
  localparam int B_START = 6;
  localparam int B_ORDER = 4;
  localparam int B_KEEP  = 3;

  logic wr_ok;
  logic unused_wbits;

  assign wr_ok        = we && !busy;
  assign start        = wr_ok && wdata[B_START];
  assign unused_wbits = ^{wdata[7], wdata[5], wdata[2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      order_q <= 1'b0;
      keep_q  <= 1'b1;
    end else if (wr_ok) begin
      order_q <= wdata[B_ORDER];
      keep_q  <= wdata[B_KEEP];
    end
  end

  always_comb begin
    rdata          = '0;
    rdata[B_START] = busy;
    rdata[B_ORDER] = order_q;
    rdata[B_KEEP]  = keep_q;
  end
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int T_RP   = 3,
  parameter int T_MRD  = 2,
  parameter int T_RFC  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              order,
  input  logic [ADDR_W-1:0] mode,
  output sdr_cmd_e          cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              busy
);
  localparam int MAX_A   = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAX_W   = (MAX_A > T_RFC) ? MAX_A : T_RFC;
  localparam int CNT_W   = $clog2(MAX_W + 1);
  localparam int LAST    = 2;
  localparam logic [CNT_W-1:0] L_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] L_MRD = CNT_W'(T_MRD - 1);
  localparam logic [CNT_W-1:0] L_RFC = CNT_W'(T_RFC - 1);
  localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

  seq_state_e        st;
  logic [1:0]        step;
  logic [CNT_W-1:0]  cnt;
  sdr_cmd_e          cur_cmd;
  logic [CNT_W-1:0]  cur_load;

  always_comb begin
    unique case (step)
      2'd0:    cur_cmd = CMD_PRE;
      2'd1:    cur_cmd = order ? CMD_MRS : CMD_REF;
      default: cur_cmd = order ? CMD_REF : CMD_MRS;
    endcase
    unique case (cur_cmd)
      CMD_PRE: cur_load = L_RP;
      CMD_MRS: cur_load = L_MRD;
      default: cur_load = L_RFC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      step <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      cmd  <= CMD_NOP;
      addr <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          cmd <= CMD_NOP;
          if (start) begin
            st   <= ST_ISSUE;
            step <= '0;
            busy <= 1'b1;
          end
        end
        ST_ISSUE: begin
          cmd <= cur_cmd;
          cnt <= cur_load;
          st  <= ST_WAIT;
          unique case (cur_cmd)
            CMD_PRE: addr <= AP_MASK;
            CMD_MRS: addr <= mode;
            default: addr <= '0;
          endcase
        end
        default: begin
          cmd <= CMD_NOP;
          if (cnt == '0) begin
            if (step == 2'(LAST)) begin
              st   <= ST_IDLE;
              busy <= 1'b0;
            end else begin
              step <= step + 2'd1;
              st   <= ST_ISSUE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sdram_clk_gate.sv
module sdram_clk_gate (
  input  logic clk,
  input  logic rst,
  input  logic keep,
  input  logic self_refresh,
  input  logic bus_released,
  output logic clk_en,
  output logic clk_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en <= 1'b1;
      clk_oe <= 1'b1;
    end else begin
      clk_en <= keep || !self_refresh;
      clk_oe <= keep || !bus_released;
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int T_RP   = 3,
  parameter int T_MRD  = 2,
  parameter int T_RFC  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hot_rst,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [ADDR_W-1:0] cfg_mode,
  input  logic              self_refresh,
  input  logic              bus_released,
  output logic              sdr_cs_n,
  output logic              sdr_ras_n,
  output logic              sdr_cas_n,
  output logic              sdr_we_n,
  output logic [ADDR_W-1:0] sdr_addr,
  output logic              busy,
  output logic              sdr_clk_en,
  output logic              sdr_clk_oe
);
  logic     order_q;
  logic     keep_q;
  logic     start;
  logic     seq_rst;
  sdr_cmd_e cmd;

  assign seq_rst = rst || hot_rst;

  sdram_init_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (reg_we && !hot_rst),
    .wdata   (reg_wdata),
    .busy    (busy),
    .order_q (order_q),
    .keep_q  (keep_q),
    .start   (start),
    .rdata   (reg_rdata)
  );

  sdram_init_fsm #(
    .ADDR_W (ADDR_W),
    .AP_BIT (AP_BIT),
    .T_RP   (T_RP),
    .T_MRD  (T_MRD),
    .T_RFC  (T_RFC)
  ) u_fsm (
    .clk   (clk),
    .rst   (seq_rst),
    .start (start),
    .order (order_q),
    .mode  (cfg_mode),
    .cmd   (cmd),
    .addr  (sdr_addr),
    .busy  (busy)
  );

  sdram_clk_gate u_gate (
    .clk          (clk),
    .rst          (rst),
    .keep         (keep_q),
    .self_refresh (self_refresh),
    .bus_released (bus_released),
    .clk_en       (sdr_clk_en),
    .clk_oe       (sdr_clk_oe)
  );

  assign {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} = cmd;
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              hot_rst,
  input logic              reg_we,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic [ADDR_W-1:0] cfg_mode,
  input logic              self_refresh,
  input logic              bus_released,
  input logic              sdr_cs_n,
  input logic              sdr_ras_n,
  input logic              sdr_cas_n,
  input logic              sdr_we_n,
  input logic [ADDR_W-1:0] sdr_addr,
  input logic              busy,
  input logic              sdr_clk_en,
  input logic              sdr_clk_oe
);
  logic [3:0] pins;
  logic       unused_wd;
  assign pins      = {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n};
  assign unused_wd = ^{reg_wdata[7], reg_wdata[5:0]};

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (rst || hot_rst)
    $rose(busy) |-> $past(reg_we && reg_wdata[6])); // R1

  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (rst || hot_rst)
    !busy |-> pins == 4'b0111); // R5

  AST_PRE_ALLBANK: assert property (@(posedge clk) disable iff (rst || hot_rst)
    pins == 4'b0010 |-> sdr_addr[AP_BIT]); // R4

  AST_MRS_VALUE: assert property (@(posedge clk) disable iff (rst || hot_rst)
    pins == 4'b0000 |-> sdr_addr == $past(cfg_mode)); // R4

  AST_ONE_CYCLE_CMD: assert property (@(posedge clk) disable iff (rst || hot_rst)
    pins != 4'b0111 |=> pins == 4'b0111); // R5

  AST_CLK_STOP: assert property (@(posedge clk) disable iff (rst || hot_rst)
    (!reg_rdata[3] && self_refresh) |=> !sdr_clk_en); // R7

  AST_PIN_HIZ: assert property (@(posedge clk) disable iff (rst || hot_rst)
    (!reg_rdata[3] && bus_released) |=> !sdr_clk_oe); // R8

  AST_CLK_KEPT: assert property (@(posedge clk) disable iff (rst || hot_rst)
    reg_rdata[3] |=> (sdr_clk_en && sdr_clk_oe)); // R9

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst || hot_rst)
    busy |=> $stable(reg_rdata[4:3])); // R6
endmodule

bind sdram_init_seq sdram_init_chk #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_chk (.*);

// File: tb/sim_sdram_init_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_seq;
  localparam int ADDR_W = 13;
  localparam int T_RP   = 3;
  localparam int T_MRD  = 2;
  localparam int T_RFC  = 7;
  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010,
                         C_REF = 4'b0001, C_MRS = 4'b0000;
  localparam logic [ADDR_W-1:0] MODE_VAL = 13'h0232;

  logic clk = 0, rst = 1, hot_rst = 0, reg_we = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [ADDR_W-1:0] cfg_mode = MODE_VAL, sdr_addr;
  logic self_refresh = 0, bus_released = 0;
  logic sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n, busy, sdr_clk_en, sdr_clk_oe;

  always #2 clk = ~clk;

  sdram_init_seq #(.ADDR_W(ADDR_W), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC)) u0 (.*);

  typedef struct {
    logic [3:0] code;
    string      req;
    int         gap;   // -1: first command, timed from the start write
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;
  int cyc = 0, last_cyc = 0, start_cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int wait_of(input logic [3:0] c);
    return (c == C_PRE) ? T_RP : (c == C_MRS) ? T_MRD : T_RFC;
  endfunction

  // monitor: pops expected commands as they appear on the pins
  always @(negedge clk) begin
    logic [3:0] code;
    exp_t it;
    code = {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n};
    if (!rst && !hot_rst && code != C_NOP) begin
      if (exp_q.size() == 0) begin
        chk(0, "R6/R11", "unexpected command", code, C_NOP);
      end else begin
        it = exp_q.pop_front();
        chk(code == it.code, it.req, "command order", code, it.code);
        if (it.gap < 0)
          chk(cyc - start_cyc == 2, "R5", "first command latency", cyc - start_cyc, 2);
        else
          chk(cyc - last_cyc == it.gap, "R5", "command gap", cyc - last_cyc, it.gap);
        if (code == C_PRE) chk(sdr_addr[10] == 1'b1, "R4", "precharge A10", sdr_addr[10], 1);
        if (code == C_MRS) chk(sdr_addr == MODE_VAL, "R4", "mode value", sdr_addr, MODE_VAL);
      end
      last_cyc = cyc;
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_wdata = 0;
  endtask

  // driver: pushes the expected series, then starts it
  task automatic run_seq(input bit ord, input string req, input bit poke);
    logic [3:0] c1, c2;
    c1 = ord ? C_MRS : C_REF;
    c2 = ord ? C_REF : C_MRS;
    exp_q.push_back('{C_PRE, req, -1});
    exp_q.push_back('{c1, req, T_RP + 1});
    exp_q.push_back('{c2, req, wait_of(c1) + 1});
    @(negedge clk);
    start_cyc = cyc;
    reg_we = 1; reg_wdata = {1'b0, 1'b1, 1'b0, ord, 1'b1, 3'b0};
    @(negedge clk);
    reg_we = 0; reg_wdata = 0;
    chk(busy == 1'b1, "R1", "busy after start", busy, 1);
    chk(reg_rdata[6] == 1'b1, "R1", "start bit reads busy", reg_rdata[6], 1);
    if (poke) begin
      reg_we = 1; reg_wdata = {1'b0, 1'b1, 1'b0, ~ord, 1'b0, 3'b0};
      @(negedge clk);
      reg_we = 0; reg_wdata = 0;
    end
    while (busy) @(negedge clk);
    chk(cyc - last_cyc == wait_of(c2), "R5", "busy fall", cyc - last_cyc, wait_of(c2));
    chk(exp_q.size() == 0, req, "commands left", exp_q.size(), 0);
    chk(reg_rdata == {3'b000, ord, 1'b1, 3'b0}, "R12", "readback after series",
        reg_rdata, {3'b000, ord, 1'b1, 3'b0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10: cold reset state
    chk(reg_rdata == 8'h08, "R10", "cold reset readback", reg_rdata, 8'h08);
    chk(busy == 0, "R10", "idle busy", busy, 0);
    chk({sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} == C_NOP, "R10", "idle NOP",
        {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n}, C_NOP);
    chk(sdr_clk_en && sdr_clk_oe, "R10", "clock controls", {sdr_clk_en, sdr_clk_oe}, 2'b11);

    run_seq(1'b0, "R2", 1'b0);
    run_seq(1'b1, "R3", 1'b0);
    run_seq(1'b0, "R6", 1'b1);  // conflicting write while busy

    // R7/R8: keep bit 0 gates clock and pin drive
    wr(8'h00);
    self_refresh = 1;
    @(negedge clk);
    chk(sdr_clk_en == 0, "R7", "clock stopped in self-refresh", sdr_clk_en, 0);
    chk(sdr_clk_oe == 1, "R8", "pin driven while bus held", sdr_clk_oe, 1);
    bus_released = 1;
    @(negedge clk);
    chk(sdr_clk_oe == 0, "R8", "pin released", sdr_clk_oe, 0);
    self_refresh = 0;
    @(negedge clk);
    chk(sdr_clk_en == 1, "R7", "clock back after self-refresh", sdr_clk_en, 1);
    self_refresh = 1;
    wr(8'h08);
    @(negedge clk);
    chk(sdr_clk_en == 1, "R9", "clock kept in self-refresh", sdr_clk_en, 1);
    chk(sdr_clk_oe == 1, "R9", "pin kept while released", sdr_clk_oe, 1);
    self_refresh = 0; bus_released = 0;

    // R11: hot reset abandons series, keeps config
    wr(8'h10);
    @(negedge clk);
    reg_we = 1; reg_wdata = 8'h50;
    @(negedge clk);
    reg_we = 0; reg_wdata = 0; hot_rst = 1;
    @(negedge clk);
    hot_rst = 0;
    repeat (12) @(negedge clk);
    chk(busy == 0, "R11", "busy after hot reset", busy, 0);
    chk(reg_rdata == 8'h10, "R11", "config kept over hot reset", reg_rdata, 8'h10);

    // R10: cold reset restores defaults
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(reg_rdata == 8'h08, "R10", "cold reset defaults", reg_rdata, 8'h08);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule